// File: doc/BRIEF.md
# CCD Erase, Row-Skip and Readout Clock Sequencer

This block produces the logic-level clock enables for a CCD: three parallel (vertical) phases, three serial (horizontal) phases, the summing well and the reset gate. It also gives a pixel-valid strobe to the sampling chain. A host issues one command at a time. The command carries an operation, a row count, a pixel count and an overscan count. The operation is one of full-array erase, row skip or row readout. A busy level and a one-cycle done pulse bracket each command.

Erase and skip move charge through the parallel register quickly. During a dump the serial register is never clocked. Every serial phase, the summing well and the reset gate stay high, so charge drains straight through the output node while the parallel phases cycle. The serial register fills to its barrier during a dump, so the block then shifts it once for the full pixel plus overscan length, with normal reset pulses. The next readout therefore starts from an empty register. The first readout row after a dump may still carry residual charge, and a configuration bit can suppress its valid strobes.

Top module: `ccd_seq`

## Requirements
- R1: After synchronous reset, and whenever busy is low, par_ph and ser_ph are 0, sum_well is 0, pix_valid and done are 0, and rst_gate is 1.
- R2: While the parallel register is dumped (erase, or skip with a row count above zero), ser_ph is 3'b111 and sum_well and rst_gate are 1 on every cycle.
- R3: Each row transfer drives par_ph through the six states 001, 000, 010, 000, 100, 000. Each state lasts dwell+1 cycles, and par_ph never has more than one bit set. Erase transfers ARRAY_ROWS rows. Skip and read transfer cmd_rows rows.
- R4: After a dump with cmd_pix+cmd_ovs above zero, a flush shifts cmd_pix+cmd_ovs serial pixels before done. Each flush pixel carries one reset-gate pulse, and pix_valid stays 0 during the flush. When the sum is zero, the flush is left out.
- R5: Every serial pixel takes four cycles: (ser_ph=001, sum_well=1, rst_gate=1), (010, 1, 0), (100, 0, 0), (001, 1, 0). In a readout, pix_valid is 1 on the fourth cycle. Each readout row is one row transfer followed by cmd_pix+cmd_ovs pixels.
- R6: If cfg_discard was 1 when an erase or skip with a row count above zero was accepted, the first readout row after it gives no pix_valid strobes. A skip of zero rows leaves this pending state unchanged.
- R7: A command is taken on a cycle with cmd_valid=1 and busy=0. The mode codes are 2'b01 erase, 2'b10 skip and 2'b11 read. Code 2'b00 is ignored, and so is any cmd_valid while busy is 1.
- R8: done is 1 for exactly the last busy cycle. With T = 6*(dwell+1) and N = cmd_pix+cmd_ovs, a dump of R rows lasts R*T + 4*N + 1 busy cycles, and a read of R rows lasts R*(T + 4*N) + 1 busy cycles.
- R9: A skip or read with cmd_rows = 0 moves no rows and runs no flush. It is busy for one cycle, with done set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 2 | 01 erase, 10 skip, 11 read, 00 none |
| cmd_rows | input | ROW_W | Rows for skip or read |
| cmd_pix | input | PIX_W | Active pixels per row |
| cmd_ovs | input | OVS_W | Overscan pixels per row |
| cfg_discard | input | 1 | Suppress strobes of the first row read after a dump |
| dwell | input | DWELL_W | Parallel state length minus one, in cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| par_ph | output | 3 | Parallel phase enables, bit 0 first |
| ser_ph | output | 3 | Serial phase enables, bit 0 first |
| sum_well | output | 1 | Summing well enable |
| rst_gate | output | 1 | Reset gate enable |
| pix_valid | output | 1 | Pixel ready for sampling |

## Verification
The bench aims at the edges between phases. One case is the handover from dump to flush. A design that started the flush a cycle late, or dropped the last flush pixel, would show the wrong busy length or shift count. Another case is the skip of zero rows. A design that ran a flush or a parallel row here would stay busy longer than one cycle. The bench also checks that a zero-row skip does not cancel a discard request armed by an earlier skip. A design that cleared the request would emit strobes for the row that should be dropped. Other cases are commands sent while busy, the do-nothing code, dwell values of 0, 1 and 2, and a zero pixel count that removes the flush.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMP,
        ST_FLUSH,
        ST_XFER,
        ST_PIX,
        ST_FIN
    } ctl_st_e;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_ERASE = 2'b01;
    localparam logic [1:0] OP_SKIP  = 2'b10;
    localparam logic [1:0] OP_READ  = 2'b11;

    localparam int unsigned PAR_STEPS = 6;
    localparam int unsigned SER_STEPS = 4;

endpackage

// File: rtl/ccd_par_gen.sv
module ccd_par_gen #(
    parameter int unsigned ROW_W   = 10,
    parameter int unsigned DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ROW_W-1:0]   rows_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic [2:0]         ph_o,
    output logic               fin_o
);
    import ccd_seq_pkg::*;

    localparam int unsigned STEP_W = $clog2(PAR_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PAR_STEPS - 1);

    typedef struct packed {
        logic               active;
        logic [STEP_W-1:0]  step;
        logic [DWELL_W-1:0] tick;
        logic [ROW_W-1:0]   left;
    } par_s;

    par_s q, d;
    logic step_end;

    always_comb begin
        d        = q;
        step_end = q.active && (q.tick == dwell_i);
        fin_o    = step_end && (q.step == LAST_STEP) && (q.left == ROW_W'(1));
        if (start_i) begin
            d.active = 1'b1;
            d.step   = '0;
            d.tick   = '0;
            d.left   = rows_i;
        end else if (q.active) begin
            if (step_end) begin
                d.tick = '0;
                if (q.step == LAST_STEP) begin
                    d.step = '0;
                    if (q.left == ROW_W'(1)) begin
                        d.active = 1'b0;
                    end else begin
                        d.left = q.left - ROW_W'(1);
                    end
                end else begin
                    d.step = q.step + STEP_W'(1);
                end
            end else begin
                d.tick = q.tick + DWELL_W'(1);
            end
        end
        // even steps drive one phase, odd steps are the non-overlap gaps
        ph_o = (q.active && !q.step[0]) ? 3'(3'b001 << q.step[STEP_W-1:1]) : 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/ccd_ser_gen.sv
module ccd_ser_gen #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [2:0]       ph_o,
    output logic             sum_o,
    output logic             rg_o,
    output logic             strobe_o,
    output logic             fin_o
);
    import ccd_seq_pkg::*;

    localparam int unsigned TICK_W = $clog2(SER_STEPS);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SER_STEPS - 1);

    typedef struct packed {
        logic              active;
        logic [TICK_W-1:0] tick;
        logic [CNT_W-1:0]  left;
    } ser_s;

    ser_s q, d;

    always_comb begin
        d     = q;
        fin_o = q.active && (q.tick == LAST_TICK) && (q.left == CNT_W'(1));
        if (start_i) begin
            d.active = 1'b1;
            d.tick   = '0;
            d.left   = count_i;
        end else if (q.active) begin
            d.tick = q.tick + TICK_W'(1);
            if (q.tick == LAST_TICK) begin
                if (q.left == CNT_W'(1)) d.active = 1'b0;
                else                     d.left   = q.left - CNT_W'(1);
            end
        end

        ph_o     = 3'b000;
        sum_o    = 1'b0;
        rg_o     = 1'b0;
        strobe_o = 1'b0;
        if (q.active) begin
            case (q.tick)
                TICK_W'(0): begin ph_o = 3'b001; sum_o = 1'b1; rg_o = 1'b1; end
                TICK_W'(1): begin ph_o = 3'b010; sum_o = 1'b1; end
                TICK_W'(2): begin ph_o = 3'b100; sum_o = 1'b0; end
                default:    begin ph_o = 3'b001; sum_o = 1'b1; strobe_o = 1'b1; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/ccd_seq.sv
module ccd_seq #(
    parameter int unsigned ROW_W      = 10,
    parameter int unsigned PIX_W      = 10,
    parameter int unsigned OVS_W      = 6,
    parameter int unsigned DWELL_W    = 4,
    parameter int unsigned ARRAY_ROWS = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_mode,
    input  logic [ROW_W-1:0]   cmd_rows,
    input  logic [PIX_W-1:0]   cmd_pix,
    input  logic [OVS_W-1:0]   cmd_ovs,
    input  logic               cfg_discard,
    input  logic [DWELL_W-1:0] dwell,
    output logic               busy,
    output logic               done,
    output logic [2:0]         par_ph,
    output logic [2:0]         ser_ph,
    output logic               sum_well,
    output logic               rst_gate,
    output logic               pix_valid
);
    import ccd_seq_pkg::*;

    localparam int unsigned CNT_W = ((PIX_W > OVS_W) ? PIX_W : OVS_W) + 1;
    localparam logic [ROW_W-1:0] FULL_ROWS = ROW_W'(ARRAY_ROWS);

    typedef struct packed {
        ctl_st_e          st;
        logic [ROW_W-1:0] rows_left;
        logic [CNT_W-1:0] npix;
        logic             arm;
        logic             drop_pend;
    } ctl_s;

    ctl_s q, d;

    logic             par_start, par_fin;
    logic [ROW_W-1:0] par_rows;
    logic [2:0]       par_ph_w;
    logic             ser_start, ser_fin, ser_sum, ser_rg, ser_strobe;
    logic [2:0]       ser_ph_w;
    logic [CNT_W-1:0] cmd_npix;
    logic             in_dump, in_flush;

    assign cmd_npix = CNT_W'(cmd_pix) + CNT_W'(cmd_ovs);

    always_comb begin
        d         = q;
        par_start = 1'b0;
        par_rows  = ROW_W'(1);
        ser_start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.npix = cmd_npix;
                    case (cmd_mode)
                        OP_ERASE: begin
                            d.st      = ST_DUMP;
                            d.arm     = cfg_discard;
                            par_start = 1'b1;
                            par_rows  = FULL_ROWS;
                        end
                        OP_SKIP: begin
                            if (cmd_rows == '0) begin
                                d.st = ST_FIN;
                            end else begin
                                d.st      = ST_DUMP;
                                d.arm     = cfg_discard;
                                par_start = 1'b1;
                                par_rows  = cmd_rows;
                            end
                        end
                        OP_READ: begin
                            if (cmd_rows == '0) begin
                                d.st = ST_FIN;
                            end else begin
                                d.st        = ST_XFER;
                                d.rows_left = cmd_rows;
                                par_start   = 1'b1;
                            end
                        end
                        default: d = q;
                    endcase
                end
            end
            ST_DUMP: begin
                if (par_fin) begin
                    if (q.npix == '0) begin
                        d.st        = ST_FIN;
                        d.drop_pend = q.arm;
                    end else begin
                        d.st      = ST_FLUSH;
                        ser_start = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (ser_fin) begin
                    d.st        = ST_FIN;
                    d.drop_pend = q.arm;
                end
            end
            ST_XFER, ST_PIX: begin
                if (q.st == ST_XFER && par_fin && q.npix != '0) begin
                    d.st      = ST_PIX;
                    ser_start = 1'b1;
                end else if ((q.st == ST_XFER && par_fin) || (q.st == ST_PIX && ser_fin)) begin
                    d.drop_pend = 1'b0;
                    if (q.rows_left == ROW_W'(1)) begin
                        d.st = ST_FIN;
                    end else begin
                        d.st        = ST_XFER;
                        d.rows_left = q.rows_left - ROW_W'(1);
                        par_start   = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_IDLE, rows_left: '0, npix: '0, arm: 1'b0, drop_pend: 1'b0};
        else     q <= d;
    end

    ccd_par_gen #(.ROW_W(ROW_W), .DWELL_W(DWELL_W)) u_par (
        .clk     (clk),
        .rst     (rst),
        .start_i (par_start),
        .rows_i  (par_rows),
        .dwell_i (dwell),
        .ph_o    (par_ph_w),
        .fin_o   (par_fin)
    );

    ccd_ser_gen #(.CNT_W(CNT_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start_i  (ser_start),
        .count_i  (q.npix),
        .ph_o     (ser_ph_w),
        .sum_o    (ser_sum),
        .rg_o     (ser_rg),
        .strobe_o (ser_strobe),
        .fin_o    (ser_fin)
    );

    assign in_dump  = (q.st == ST_DUMP);
    assign in_flush = (q.st == ST_FLUSH);
    assign busy     = (q.st != ST_IDLE);
    assign done     = (q.st == ST_FIN);

    always_comb begin
        par_ph    = 3'b000;
        ser_ph    = 3'b000;
        sum_well  = 1'b0;
        rst_gate  = 1'b1;
        pix_valid = 1'b0;
        case (q.st)
            ST_DUMP: begin
                par_ph   = par_ph_w;
                ser_ph   = 3'b111;
                sum_well = 1'b1;
            end
            ST_XFER: begin
                par_ph   = par_ph_w;
                rst_gate = 1'b0;
            end
            ST_FLUSH, ST_PIX: begin
                ser_ph    = ser_ph_w;
                sum_well  = ser_sum;
                rst_gate  = ser_rg;
                pix_valid = (q.st == ST_PIX) && ser_strobe && !q.drop_pend;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_mode,
    input logic       busy,
    input logic       done,
    input logic [2:0] par_ph,
    input logic [2:0] ser_ph,
    input logic       sum_well,
    input logic       rst_gate,
    input logic       pix_valid,
    input logic       in_dump,
    input logic       in_flush
);

    p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (par_ph == 3'b000 && ser_ph == 3'b000 && !sum_well && rst_gate && !pix_valid && !done));

    p_out_of_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !busy);

    p_dump_levels_r2: assert property (@(posedge clk) disable iff (rst)
        in_dump |-> (ser_ph == 3'b111 && sum_well && rst_gate && !pix_valid));

    p_par_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(par_ph));

    p_flush_silent_r4: assert property (@(posedge clk) disable iff (rst)
        in_flush |-> !pix_valid);

    p_valid_after_sum_r5: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (sum_well && !rst_gate && $past(ser_ph) == 3'b100 && !$past(sum_well)));

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && cmd_mode != 2'b00) |=> busy);

    p_nop_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && cmd_mode == 2'b00) |=> !busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

bind ccd_seq ccd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .busy      (busy),
    .done      (done),
    .par_ph    (par_ph),
    .ser_ph    (ser_ph),
    .sum_well  (sum_well),
    .rst_gate  (rst_gate),
    .pix_valid (pix_valid),
    .in_dump   (in_dump),
    .in_flush  (in_flush)
);

// File: tb/ccd_seq_bench.sv
module ccd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 10, PIX_W = 10, OVS_W = 6, DWELL_W = 4, ARRAY = 48;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, cfg_discard = 1'b0;
    logic [1:0] cmd_mode = 2'b00;
    logic [ROW_W-1:0] cmd_rows = '0;
    logic [PIX_W-1:0] cmd_pix = '0;
    logic [OVS_W-1:0] cmd_ovs = '0;
    logic [DWELL_W-1:0] dwell = '0;
    logic busy, done, sum_well, rst_gate, pix_valid;
    logic [2:0] par_ph, ser_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_seq #(.ROW_W(ROW_W), .PIX_W(PIX_W), .OVS_W(OVS_W), .DWELL_W(DWELL_W),
              .ARRAY_ROWS(ARRAY)) u_ccd_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_rows(cmd_rows), .cmd_pix(cmd_pix), .cmd_ovs(cmd_ovs),
        .cfg_discard(cfg_discard), .dwell(dwell), .busy(busy), .done(done),
        .par_ph(par_ph), .ser_ph(ser_ph), .sum_well(sum_well),
        .rst_gate(rst_gate), .pix_valid(pix_valid));

    typedef struct {
        int cycles;
        int valids;
        int rows;
        int shifts;
        bit dump;
        int dumpcyc;
    } exp_t;

    exp_t sb[$];
    int checks = 0, errors = 0;
    bit exp_pend = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] mode, input int rows, input int pix,
                         input int ovs, input bit disc);
        exp_t e;
        int t, n;
        do @(negedge clk); while (busy || sb.size() != 0);
        cmd_mode = mode; cmd_rows = ROW_W'(rows); cmd_pix = PIX_W'(pix);
        cmd_ovs = OVS_W'(ovs); cfg_discard = disc; cmd_valid = 1'b1;
        t = 6 * (int'(dwell) + 1);
        n = pix + ovs;
        if (mode == 2'b01) rows = ARRAY;
        e = '{cycles: 1, valids: 0, rows: 0, shifts: 0, dump: 1'b0, dumpcyc: 0};
        if (mode != 2'b11 && rows > 0) begin
            e = '{cycles: rows*t + 4*n + 1, valids: 0, rows: rows, shifts: n,
                  dump: 1'b1, dumpcyc: rows*t};
            exp_pend = disc;
        end else if (mode == 2'b11 && rows > 0) begin
            e = '{cycles: rows*(t + 4*n) + 1, valids: rows*n - (exp_pend ? n : 0),
                  rows: rows, shifts: rows*n, dump: 1'b0, dumpcyc: 0};
            exp_pend = 1'b0;
        end
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // monitor
    int cyc = 0, nval = 0, nshift = 0, nrg = 0, nrow = 0;
    bit bad2 = 0, bad3 = 0, bad5 = 0, prev_p0 = 0, prev_sum = 0, prev_done = 0;
    logic [2:0] prev_ser = 3'b000;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk(!done && !busy, "R8 done single cycle", int'(done), 0);
            if (busy) begin
                cyc++;
                if (pix_valid) nval++;
                if (ser_ph == 3'b010) nshift++;
                if (rst_gate && ser_ph == 3'b001 && sum_well) nrg++;
                if (par_ph[0] && !prev_p0) nrow++;
                if (!$onehot0(par_ph)) bad3 = 1;
                if (sb.size() > 0 && sb[0].dump && cyc <= sb[0].dumpcyc &&
                    (ser_ph != 3'b111 || !sum_well || !rst_gate)) bad2 = 1;
                if (pix_valid && (prev_sum || prev_ser != 3'b100)) bad5 = 1;
                if (done) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R7 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(cyc == e.cycles, "R8/R9 busy cycles", cyc, e.cycles);
                        chk(nval == e.valids, "R5/R6 valid strobes", nval, e.valids);
                        chk(nrow == e.rows, "R3 row transfers", nrow, e.rows);
                        chk(nshift == e.shifts, "R4/R5 serial shifts", nshift, e.shifts);
                        chk(nrg == e.shifts, "R4 reset pulses", nrg, e.shifts);
                        chk(!bad2, "R2 dump levels", int'(bad2), 0);
                        chk(!bad3, "R3 par one-hot", int'(bad3), 0);
                        chk(!bad5, "R5 pixel order", int'(bad5), 0);
                    end
                    cyc = 0; nval = 0; nshift = 0; nrg = 0; nrow = 0;
                    bad2 = 0; bad3 = 0; bad5 = 0;
                end
            end
            prev_p0 = par_ph[0]; prev_sum = sum_well; prev_ser = ser_ph; prev_done = done;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            checks++; errors++;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && par_ph == 0 && ser_ph == 0 && !sum_well && rst_gate && !pix_valid,
            "R1 reset levels", {busy, done, par_ph, ser_ph, sum_well, rst_gate}, 1);
        rst = 1'b0;
        dwell = 4'd1;
        @(negedge clk);
        // R7 do-nothing code
        cmd_mode = 2'b00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy, "R7 mode 00 ignored", int'(busy), 0);
        @(negedge clk);
        chk(!busy && rst_gate && par_ph == 0, "R1 idle levels", int'(busy), 0);

        // erase, with an ignored command while busy (R7)
        issue(2'b01, 0, 8, 2, 1'b0);
        repeat (20) @(negedge clk);
        cmd_mode = 2'b11; cmd_rows = 10'd2; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        issue(2'b11, 3, 8, 2, 1'b0);        // R5 plain readout
        issue(2'b10, 5, 6, 1, 1'b1);        // R2/R4 skip, discard armed
        issue(2'b11, 2, 6, 1, 1'b0);        // R6 first row dropped
        issue(2'b10, 4, 5, 0, 1'b1);        // arm again
        issue(2'b10, 0, 5, 0, 1'b0);        // R9 zero skip keeps request
        issue(2'b11, 2, 5, 0, 1'b0);        // R6 still dropped
        issue(2'b11, 0, 5, 0, 1'b0);        // R9 zero read
        do @(negedge clk); while (busy || sb.size() != 0);
        dwell = 4'd0;
        issue(2'b11, 4, 3, 0, 1'b0);        // R3 dwell 0
        do @(negedge clk); while (busy || sb.size() != 0);
        dwell = 4'd2;
        issue(2'b10, 3, 0, 0, 1'b1);        // R4 no flush when count is zero
        issue(2'b11, 1, 2, 1, 1'b0);        // R6 row dropped after flushless skip
        issue(2'b11, 1, 2, 1, 1'b0);        // R6 cleared afterwards
        do @(negedge clk); while (busy || sb.size() != 0);
        repeat (3) @(negedge clk);
        chk(!busy && rst_gate, "R1 idle after run", int'(busy), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule